// File: doc/BRIEF.md
# UART Interrupt Status and Threshold Unit

This block gathers every interrupt condition of a serial port into one sticky status word. The word has eleven bits. Four modem-line change events and four receive error events arrive as one-cycle pulses. Three conditions are derived inside the block:
- receive FIFO fill reaching a programmable level,
- transmit FIFO drain reaching a programmable level,
- a receive idle timeout measured in bit periods.

A mask register selects which status bits may drive the single interrupt line. Software acknowledges a source by writing a one to its position in a clear strobe.

The receive and transmit levels come from a 6-bit threshold register. Each direction holds a 3-bit code that selects a fraction of the FIFO depth. The FIFO occupancy counts are inputs, so the block does not depend on how the FIFOs are built. A `bit_tick` pulse, asserted once per serial bit period, paces the idle timeout.

Top module: `uart_irq_unit`

## Requirements
- R1: Status bit positions are: 0 RI change, 1 CTS change, 2 DCD change, 3 DSR change, 4 receive level, 5 transmit level, 6 receive timeout, 7 framing error, 8 parity error, 9 break error, 10 overrun error.
- R2: `masked_status` is `raw_status` ANDed with the mask register. A `mask_we` cycle loads `mask_wdata` into the mask, and the new mask takes effect at the next clock edge. Example: raw 0x609 with mask 0x401 gives masked 0x401.
- R3: A `clr_we` cycle clears each raw bit whose `clr_wdata` bit is one. Bits written as zero are left unchanged.
- R4: A raw bit stays set until it is cleared. It never drops on its own.
- R5: `lvl_wdata[5:3]` is the receive code and `lvl_wdata[2:0]` is the transmit code; both load on `lvl_we`, reset to 000 and act from the next cycle. With depth D, codes 000, 001, 010, 011 and 100 select D/8, D/4, D/2, 3D/4 and 7D/8 entries (4, 8, 16, 24 and 28 for D=32). Codes 101 to 111 act as 100.
- R6: Bit 4 sets on the cycle in which `rx_count >= receive level` becomes true after having been false. It does not set again while the condition stays true.
- R7: Bit 5 sets on the cycle in which `tx_count <= transmit level` becomes true after having been false. The condition counts as already true at reset, so it does not fire just after reset.
- R8: Bit 6 sets on the 32nd `bit_tick` counted while `rx_count` is nonzero and no `rx_char` has arrived. The count restarts on `rx_char` or on an empty receive FIFO. The bit fires only once per restart.
- R9: `irq` is high exactly when any `masked_status` bit is high.
- R10: When a set event and a clear write hit the same bit in the same cycle, the bit ends up set.
- R11: During and straight after reset, the raw status, the mask and the masked status are zero and `irq` is low, whatever pulses are present.
- R12: `rx_err_evt` bits 3..0 (overrun, break, parity, framing) set raw bits 10..7. `modem_evt` bits 3..0 (DSR, CTS... in order DSR, DCD, CTS, RI) set raw bits 3..0. Both take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_count | input | 6 | Receive FIFO occupancy |
| tx_count | input | 6 | Transmit FIFO occupancy |
| rx_char | input | 1 | Pulse: a character entered the receive FIFO |
| bit_tick | input | 1 | Pulse once per serial bit period |
| rx_err_evt | input | 4 | Error pulses: overrun, break, parity, framing |
| modem_evt | input | 4 | Modem change pulses: DSR, DCD, CTS, RI |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 11 | Mask write value |
| clr_we | input | 1 | Clear strobe |
| clr_wdata | input | 11 | Ones select raw bits to clear |
| lvl_we | input | 1 | Threshold register write strobe |
| lvl_wdata | input | 6 | Receive code [5:3], transmit code [2:0] |
| raw_status | output | 11 | Sticky raw interrupt status |
| masked_status | output | 11 | Raw status ANDed with the mask |
| irq | output | 1 | Combined interrupt line |

## Verification
The following are checked on every cycle by assertions:
- a cleared bit drops unless it is set again in the same cycle, and raw bits never fall without a clear,
- every set event lands in the status word,
- the masked word never shows a bit that is absent from the raw word,
- no timeout event occurs while the receive FIFO is empty.

Other behaviours can only be shown by the bench scenarios:
- the threshold decoding of every code, including the reserved codes,
- the edge-only nature of the level interrupts,
- the exact 32-tick timeout with its single firing and its restart on a new character,
- the mask example and the interrupt line.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int IRQ_N  = 11;
   localparam int IX_RI  = 0;
   localparam int IX_CTS = 1;
   localparam int IX_DCD = 2;
   localparam int IX_DSR = 3;
   localparam int IX_RX  = 4;
   localparam int IX_TX  = 5;
   localparam int IX_RTO = 6;
   localparam int IX_FRM = 7;
   localparam int IX_PAR = 8;
   localparam int IX_BRK = 9;
   localparam int IX_OVR = 10;

   // Threshold code to FIFO entries; reserved codes act as the top code.
   function automatic int unsigned level_entries(input logic [2:0] code,
                                                 input int unsigned depth);
      case (code)
         3'd0:    return depth / 8;
         3'd1:    return depth / 4;
         3'd2:    return depth / 2;
         3'd3:    return (depth / 4) * 3;
         default: return (depth / 8) * 7;
      endcase
   endfunction
endpackage

// File: rtl/irq_level_detect.sv
module irq_level_detect #(
   parameter int CNT_W = 6,
   parameter int DEPTH = 32,
   parameter bit ABOVE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [2:0]       code,
   output logic             set_pulse
);
   import uart_irq_pkg::*;

   logic [CNT_W-1:0] lvl;
   logic             cond;
   logic             cond_q;

   always_comb lvl = CNT_W'(level_entries(code, DEPTH));

   generate
      if (ABOVE) begin : g_fill
         always_comb cond = (count >= lvl);
      end else begin : g_drain
         always_comb cond = (count <= lvl);
      end
   endgenerate

   // Condition taken as true at reset: only a fresh entry fires.
   always_ff @(posedge clk) begin
      if (!rst_n) cond_q <= 1'b1;
      else        cond_q <= cond;
   end

   assign set_pulse = cond & ~cond_q;
endmodule

// File: rtl/irq_rx_timeout.sv
module irq_rx_timeout #(
   parameter int CNT_W        = 6,
   parameter int TIMEOUT_BITS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rx_count,
   input  logic             rx_char,
   input  logic             bit_tick,
   output logic             fire
);
   localparam int TW = $clog2(TIMEOUT_BITS + 1);

   logic [TW-1:0] cnt;
   logic          restart;

   assign restart = rx_char | (rx_count == '0);
   assign fire    = ~restart & bit_tick & (cnt == TW'(TIMEOUT_BITS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)                                        cnt <= '0;
      else if (restart)                                  cnt <= '0;
      else if (bit_tick && cnt != TW'(TIMEOUT_BITS))     cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
   parameter int N = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic         clr_we,
   input  logic [N-1:0] clr_wdata,
   input  logic         mask_we,
   input  logic [N-1:0] mask_wdata,
   output logic [N-1:0] raw,
   output logic [N-1:0] mask
);
   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_bit
         // Set has priority over a same-cycle clear.
         always_ff @(posedge clk) begin
            if (!rst_n) raw[i] <= 1'b0;
            else        raw[i] <= set_vec[i] | (raw[i] & ~(clr_we & clr_wdata[i]));
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       mask <= '0;
      else if (mask_we) mask <= mask_wdata;
   end
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit #(
   parameter int FIFO_DEPTH   = 32,
   parameter int TIMEOUT_BITS = 32,
   localparam int CNT_W       = $clog2(FIFO_DEPTH) + 1,
   localparam int N           = uart_irq_pkg::IRQ_N
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] tx_count,
   input  logic             rx_char,
   input  logic             bit_tick,
   input  logic [3:0]       rx_err_evt,
   input  logic [3:0]       modem_evt,
   input  logic             mask_we,
   input  logic [N-1:0]     mask_wdata,
   input  logic             clr_we,
   input  logic [N-1:0]     clr_wdata,
   input  logic             lvl_we,
   input  logic [5:0]       lvl_wdata,
   output logic [N-1:0]     raw_status,
   output logic [N-1:0]     masked_status,
   output logic             irq
);
   import uart_irq_pkg::*;

   generate
      if (FIFO_DEPTH < 8 || (FIFO_DEPTH % 8) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a multiple of 8, at least 8");
      end
      if (TIMEOUT_BITS < 2) begin : g_bad_timeout
         $error("TIMEOUT_BITS must be at least 2");
      end
   endgenerate

   logic [5:0]   lvl_q;
   logic [N-1:0] set_vec;
   logic [N-1:0] mask_q;
   logic         rx_set, tx_set, to_set;

   always_ff @(posedge clk) begin
      if (!rst_n)      lvl_q <= '0;
      else if (lvl_we) lvl_q <= lvl_wdata;
   end

   irq_level_detect #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH), .ABOVE(1'b1)) u_rx_lvl (
      .clk(clk), .rst_n(rst_n), .count(rx_count), .code(lvl_q[5:3]), .set_pulse(rx_set));

   irq_level_detect #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH), .ABOVE(1'b0)) u_tx_lvl (
      .clk(clk), .rst_n(rst_n), .count(tx_count), .code(lvl_q[2:0]), .set_pulse(tx_set));

   irq_rx_timeout #(.CNT_W(CNT_W), .TIMEOUT_BITS(TIMEOUT_BITS)) u_rto (
      .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .rx_char(rx_char),
      .bit_tick(bit_tick), .fire(to_set));

   always_comb begin
      set_vec         = '0;
      set_vec[IX_OVR] = rx_err_evt[3];
      set_vec[IX_BRK] = rx_err_evt[2];
      set_vec[IX_PAR] = rx_err_evt[1];
      set_vec[IX_FRM] = rx_err_evt[0];
      set_vec[IX_RTO] = to_set;
      set_vec[IX_TX]  = tx_set;
      set_vec[IX_RX]  = rx_set;
      set_vec[IX_DSR] = modem_evt[3];
      set_vec[IX_DCD] = modem_evt[2];
      set_vec[IX_CTS] = modem_evt[1];
      set_vec[IX_RI]  = modem_evt[0];
   end

   irq_status_reg #(.N(N)) u_stat (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_we(clr_we),
      .clr_wdata(clr_wdata), .mask_we(mask_we), .mask_wdata(mask_wdata),
      .raw(raw_status), .mask(mask_q));

   assign masked_status = raw_status & mask_q;
   assign irq           = |masked_status;
endmodule

// File: rtl/uart_irq_unit_chk.sv
module uart_irq_unit_chk #(
   parameter int CW = 6,
   parameter int N  = 11
) (
   input logic          clk,
   input logic          rst_n,
   input logic [CW-1:0] rx_count,
   input logic          clr_we,
   input logic [N-1:0]  clr_wdata,
   input logic [N-1:0]  set_vec,
   input logic [N-1:0]  raw_status,
   input logic [N-1:0]  masked_status
);
   import uart_irq_pkg::*;

   // R3: cleared bits drop unless set again
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((raw_status & $past(clr_wdata) & ~$past(set_vec)) == '0));

   // R4: no bit falls without a clear
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((raw_status & $past(raw_status)) == $past(raw_status)));

   // R10: every set event lands, even against a clear
   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((raw_status & $past(set_vec)) == $past(set_vec)));

   // R2: masked word is a subset of raw
   p_masked_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (masked_status & ~raw_status) == '0);

   // R8: no timeout event on an empty receive FIFO
   p_no_to_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count == '0) |-> !set_vec[IX_RTO]);
endmodule

bind uart_irq_unit uart_irq_unit_chk #(.CW(CNT_W), .N(N)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .clr_we(clr_we),
   .clr_wdata(clr_wdata), .set_vec(set_vec), .raw_status(raw_status),
   .masked_status(masked_status));

// File: tb/uart_irq_unit_bench.sv
module uart_irq_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  rx_count = '0, tx_count = '0;
   logic        rx_char = 1'b0, bit_tick = 1'b0;
   logic [3:0]  rx_err_evt = '0, modem_evt = '0;
   logic        mask_we = 1'b0, clr_we = 1'b0, lvl_we = 1'b0;
   logic [10:0] mask_wdata = '0, clr_wdata = '0;
   logic [5:0]  lvl_wdata = '0;
   logic [10:0] raw_status, masked_status;
   logic        irq;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   logic [10:0] m_raw = '0, m_mask = '0;
   logic [5:0]  m_lvl = '0;
   bit          m_rxq = 1'b1, m_txq = 1'b1;
   int          m_tc = 0;

   always #5 clk = ~clk;

   uart_irq_unit u_uart_irq_unit (
      .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
      .rx_char(rx_char), .bit_tick(bit_tick), .rx_err_evt(rx_err_evt),
      .modem_evt(modem_evt), .mask_we(mask_we), .mask_wdata(mask_wdata),
      .clr_we(clr_we), .clr_wdata(clr_wdata), .lvl_we(lvl_we),
      .lvl_wdata(lvl_wdata), .raw_status(raw_status),
      .masked_status(masked_status), .irq(irq));

   function automatic int lvl_of(input logic [2:0] code);
      case (code)
         3'd0: return 4;
         3'd1: return 8;
         3'd2: return 16;
         3'd3: return 24;
         default: return 28;
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic check_model(input string tag);
      chk({tag, " raw"}, int'(raw_status), int'(m_raw));
      chk({tag, " masked"}, int'(masked_status), int'(m_raw & m_mask));
      chk({tag, " irq (R9)"}, int'(irq), int'((m_raw & m_mask) != 0));
   endtask

   task automatic idle();
      rx_err_evt = '0; modem_evt = '0; rx_char = 1'b0;
      mask_we = 1'b0; clr_we = 1'b0; lvl_we = 1'b0;
   endtask

   // One clock: model next state from current inputs, then compare.
   task automatic cycle(input string tag);
      logic [10:0] set, nraw;
      bit rx_c, tx_c, restart;
      int nt;
      rx_c = int'(rx_count) >= lvl_of(m_lvl[5:3]);
      tx_c = int'(tx_count) <= lvl_of(m_lvl[2:0]);
      set = '0;
      set[10:7] = rx_err_evt;
      set[3:0]  = modem_evt;
      set[4] = rx_c && !m_rxq;
      set[5] = tx_c && !m_txq;
      restart = rx_char || (rx_count == 0);
      if (!restart && bit_tick && m_tc == 31) set[6] = 1'b1;
      nt = restart ? 0 : ((bit_tick && m_tc < 32) ? m_tc + 1 : m_tc);
      nraw = (m_raw & ~(clr_we ? clr_wdata : 11'h0)) | set;
      @(posedge clk);
      m_raw = nraw; m_rxq = rx_c; m_txq = tx_c; m_tc = nt;
      if (mask_we) m_mask = mask_wdata;
      if (lvl_we)  m_lvl  = lvl_wdata;
      @(negedge clk);
      check_model(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      // R11: reset state with pulses present
      modem_evt = 4'hF; rx_err_evt = 4'hF;
      repeat (3) @(negedge clk);
      chk("R11 raw in reset", int'(raw_status), 0);
      chk("R11 masked in reset", int'(masked_status), 0);
      chk("R11 irq in reset", int'(irq), 0);
      idle();
      rst_n = 1'b1;
      cycle("R11 after reset");
      chk("R7 no tx fire after reset", int'(raw_status[5]), 0);

      // R12 / R1: event pulses to bit positions
      rx_err_evt = 4'b1001; modem_evt = 4'b0101;
      cycle("R12 events");
      chk("R12 R1 positions", int'(raw_status), 'h485);
      idle();
      cycle("R4 sticky");

      // R2: mask example
      clr_we = 1'b1; clr_wdata = 11'h7FF; cycle("R3 clear all"); idle();
      rx_err_evt = 4'b1100; modem_evt = 4'b1001;
      mask_we = 1'b1; mask_wdata = 11'h401;
      cycle("R2 setup"); idle();
      chk("R2 raw", int'(raw_status), 'h609);
      chk("R2 masked", int'(masked_status), 'h401);
      chk("R9 irq high", int'(irq), 1);

      // R3: ones clear, zeros keep
      clr_we = 1'b1; clr_wdata = 11'h008; cycle("R3 partial"); idle();
      chk("R3 partial clear", int'(raw_status), 'h601);

      // R10: set beats clear
      modem_evt = 4'b0001; clr_we = 1'b1; clr_wdata = 11'h001;
      cycle("R10 collide"); idle();
      chk("R10 set wins", int'(raw_status[0]), 1);

      // R9
      clr_we = 1'b1; clr_wdata = 11'h400; cycle("R9 a"); idle();
      chk("R9 still high", int'(irq), 1);
      clr_we = 1'b1; clr_wdata = 11'h001; cycle("R9 b"); idle();
      chk("R9 low", int'(irq), 0);

      // R5 / R6: every receive code including reserved
      for (int c = 0; c < 8; c++) begin
         rx_count = 0; lvl_we = 1'b1; lvl_wdata = {3'(c), 3'b111};
         cycle("R5 write"); idle();
         rx_count = 6'(lvl_of(3'(c)) - 1); cycle("R6 below");
         chk("R6 below level", int'(raw_status[4]), 0);
         rx_count = 6'(lvl_of(3'(c))); cycle("R6 at level");
         chk("R5 R6 at level", int'(raw_status[4]), 1);
         clr_we = 1'b1; clr_wdata = 11'h010; cycle("R6 clear"); idle();
         cycle("R6 held");
         chk("R6 no refire", int'(raw_status[4]), 0);
      end

      // R7: transmit drain
      rx_count = 0; lvl_we = 1'b1; lvl_wdata = 6'b100_010; tx_count = 30;
      cycle("R7 setup"); idle();
      clr_we = 1'b1; clr_wdata = 11'h7FF; cycle("R7 clr"); idle();
      tx_count = 17; cycle("R7 above");
      chk("R7 above level", int'(raw_status[5]), 0);
      tx_count = 16; cycle("R7 at level");
      chk("R7 at level", int'(raw_status[5]), 1);

      // R8: receive timeout
      clr_we = 1'b1; clr_wdata = 11'h7FF; cycle("R8 clr"); idle();
      rx_count = 1; bit_tick = 1'b1;
      for (int k = 0; k < 31; k++) cycle("R8 count");
      chk("R8 before 32", int'(raw_status[6]), 0);
      cycle("R8 32nd");
      chk("R8 at 32", int'(raw_status[6]), 1);
      clr_we = 1'b1; clr_wdata = 11'h040; cycle("R8 clr2"); idle();
      for (int k = 0; k < 40; k++) cycle("R8 once");
      chk("R8 fires once", int'(raw_status[6]), 0);
      rx_char = 1'b1; cycle("R8 restart"); rx_char = 1'b0;
      for (int k = 0; k < 32; k++) cycle("R8 recount");
      chk("R8 after restart", int'(raw_status[6]), 1);
      bit_tick = 1'b0;

      // R4: constrained random mix
      for (int n = 0; n < 4000; n++) begin
         idle();
         if ($urandom_range(0, 7) == 0) rx_count = 6'($urandom_range(0, 32));
         if ($urandom_range(0, 7) == 0) tx_count = 6'($urandom_range(0, 32));
         bit_tick = 1'($urandom_range(0, 1));
         rx_char  = ($urandom_range(0, 19) == 0);
         rx_err_evt = ($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'h0;
         modem_evt  = ($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'h0;
         if ($urandom_range(0, 5) == 0) begin clr_we = 1'b1; clr_wdata = 11'($urandom); end
         if ($urandom_range(0, 9) == 0) begin mask_we = 1'b1; mask_wdata = 11'($urandom); end
         if ($urandom_range(0, 19) == 0) begin lvl_we = 1'b1; lvl_wdata = 6'($urandom); end
         cycle("R4 random");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule